// File: doc/BRIEF.md
# Three-Wire Serial Shift Engine

This block is a byte-wide serial shifter for three-wire links. It can work as either end of an SPI link in data modes 0 and 1. Its 8-bit data register sends its most significant bit first on the serial output. At the same time it collects the serial input at the least significant end, so after eight bit periods the register holds the byte received from the partner.

A 4-bit counter advances on every edge of the serial clock, both rising and falling. It therefore wraps after 16 edges, which is one byte. At the wrap it sets a sticky completion flag, and that flag can raise an interrupt. Two sources can drive the serial clock:
- an internal clock bit that the host inverts with a strobe in the control register, so two strobe writes make one pulse;
- an external clock pin, which first passes through a synchroniser.

A select bit in the control register picks which edge samples the input and which edge shifts the register.

The host reaches three registers through a plain write/read bus:
- **data** (address 0): the 8-bit shift register.
- **status** (address 1): the completion flag in bit 7 and the counter in bits 3:0.
- **control** (address 2): bit 0 is the toggle strobe, bit 1 the edge mode, bit 2 the internal clock select, and bit 3 the interrupt enable.

Top module: `tw_shift_engine`

## Requirements
- R1: After reset the data register, counter, flag, control bits, `sck_o`, `do_o` and `irq_o` are all zero.
- R2: In edge mode 0 (control bit 1 = 0), `di_i` is captured on rising serial-clock edges and the register shifts on falling edges.
- R3: In edge mode 1 (control bit 1 = 1), `di_i` is captured on falling edges and the register shifts on rising edges.
- R4: Shifting is MSB first. The captured input bit enters at bit 0. `do_o` is a registered copy of the register MSB and changes only on a shift edge or a data write. After eight shifts the data register (address 0) reads back the received byte.
- R5: The counter (status bits 3:0) increments by one on every edge of the selected serial clock, both rising and falling.
- R6: An edge that takes the counter from 15 to 0 sets the completion flag (status bit 7).
- R7: Writing control with bit 0 = 1 inverts `sck_o` one cycle later. Control bit 0 always reads back as 0.
- R8: A status write loads bits 3:0 into the counter. If bit 7 of that write is 1 it clears the flag; if bit 7 is 0 it leaves the flag unchanged.
- R9: `irq_o` is high exactly when the flag and the interrupt enable (control bit 3) are both set.
- R10: With control bit 2 = 1 the serial clock is the internal toggle bit and `sck_i` is ignored. With control bit 2 = 0 the serial clock is `sck_i`, taken through a synchroniser.
- R11: A data write loads the register, and `do_o` shows bit 7 of the written byte from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 data, 1 status, 2 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| sck_i | input | 1 | External serial clock pin |
| sck_o | output | 1 | Internal toggle-driven serial clock |
| di_i | input | 1 | Serial data input |
| do_o | output | 1 | Serial data output |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench acts as the partner device. It exchanges bytes in both directions, using directed patterns (alternating bits, 0x00/0xFF) and seeded random bytes. This is done in edge mode 0 starting from an idle-low clock, in edge mode 1 starting from an idle-high clock, and once with the clock driven on the external pin.

Checks on `do_o` at every sampling point separate a correct MSB-first shift on the proper edge from a swapped edge or a reversed bit order. Counter and flag reads after every edge separate counting both edges from counting one, and show whether the wrap sets the flag at the 16th edge. Wiggling `sck_i` while the internal clock is selected, status writes with and without bit 7, and interrupt-enable changes exercise the gating and the load paths.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;

  // control field positions
  localparam int unsigned CTRL_TGL  = 0;
  localparam int unsigned CTRL_MODE = 1;
  localparam int unsigned CTRL_INT  = 2;
  localparam int unsigned CTRL_IE   = 3;

  typedef struct packed {
    logic irq_en;
    logic int_clk;
    logic mode;
  } ctrl_t;
endpackage

// File: rtl/tw_sck_edge.sv
module tw_sck_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_pin_i,
  input  logic tgl_i,
  input  logic int_clk_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q, sck_prev, pin_s, sck_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sck_q <= 1'b0;
    else if (tgl_i) sck_q <= ~sck_q;
  end

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= 1'b0;
        else         s_q <= sck_pin_i;
      end
      assign pin_s = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= {s_q[SYNC_STAGES-2:0], sck_pin_i};
      end
      assign pin_s = s_q[SYNC_STAGES-1];
    end
  endgenerate

  assign sck_sel = int_clk_i ? sck_q : pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_prev <= 1'b0;
    else         sck_prev <= sck_sel;
  end

  assign rise_o = sck_sel & ~sck_prev;
  assign fall_o = ~sck_sel & sck_prev;
  assign sck_o  = sck_q;

  AST_TOGGLE_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgl_i |=> sck_q != $past(sck_q)); // R7
endmodule

// File: rtl/tw_shift_reg.sv
module tw_shift_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_data_i,
  input  logic         sample_i,
  input  logic         shift_i,
  input  logic         di_i,
  output logic [W-1:0] data_o,
  output logic         do_o
);
  logic [W-1:0] data_q;
  logic         di_lat, do_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       di_lat <= 1'b0;
    else if (sample_i) di_lat <= di_i;
  end

  // a bus write wins over a coincident shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      do_q   <= 1'b0;
    end else if (ld_i) begin
      data_q <= ld_data_i;
      do_q   <= ld_data_i[W-1];
    end else if (shift_i) begin
      data_q <= {data_q[W-2:0], di_lat};
      do_q   <= data_q[W-2];
    end
  end

  assign data_o = data_q;
  assign do_o   = do_q;

  AST_DO_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i && !shift_i |=> $stable(do_q)); // R4
  AST_LOAD_DO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> do_q == $past(ld_data_i[W-1])); // R11
endmodule

// File: rtl/tw_edge_cnt.sv
module tw_edge_cnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          edge_i,
  input  logic          ld_i,
  input  logic [CW-1:0] ld_val_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          flag_o
);
  logic [CW-1:0] cnt_q;
  logic          flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (ld_i)     cnt_q <= ld_val_i;
    else if (edge_i)   cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             flag_q <= 1'b0;
    else if (clr_i)                          flag_q <= 1'b0;
    else if (edge_i && !ld_i && &cnt_q)      flag_q <= 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i && !ld_i |=> cnt_q == $past(cnt_q) + CW'(1)); // R5
  AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i && !ld_i && !clr_i && cnt_q == '1 |=> flag_q); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i |=> flag_q); // R8
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_q == $past(ld_val_i)); // R8
endmodule

// File: rtl/tw_shift_engine.sv
module tw_shift_engine
  import tw_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sck_i,
  output logic              sck_o,
  input  logic              di_i,
  output logic              do_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(2 * DATA_W);

  ctrl_t             ctrl_q;
  logic              wr_data, wr_stat, wr_ctrl, tgl;
  logic              rise, fall, sample, shift;
  logic [DATA_W-1:0] data;
  logic [CNT_W-1:0]  cnt;
  logic              flag;

  assign wr_data = wr_en_i && addr_i == ADDR_DATA;
  assign wr_stat = wr_en_i && addr_i == ADDR_STAT;
  assign wr_ctrl = wr_en_i && addr_i == ADDR_CTRL;
  assign tgl     = wr_ctrl && wdata_i[CTRL_TGL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ctrl) begin
      ctrl_q.irq_en  <= wdata_i[CTRL_IE];
      ctrl_q.int_clk <= wdata_i[CTRL_INT];
      ctrl_q.mode    <= wdata_i[CTRL_MODE];
    end
  end

  tw_sck_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni,
    .sck_pin_i (sck_i),
    .tgl_i     (tgl),
    .int_clk_i (ctrl_q.int_clk),
    .sck_o     (sck_o),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  // mode 0: sample on rise, shift on fall; mode 1 swaps
  assign sample = ctrl_q.mode ? fall : rise;
  assign shift  = ctrl_q.mode ? rise : fall;

  tw_shift_reg #(.W(DATA_W)) u_sreg (
    .clk_i, .rst_ni,
    .ld_i      (wr_data),
    .ld_data_i (wdata_i),
    .sample_i  (sample),
    .shift_i   (shift),
    .di_i      (di_i),
    .data_o    (data),
    .do_o      (do_o)
  );

  tw_edge_cnt #(.CW(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .edge_i   (rise | fall),
    .ld_i     (wr_stat),
    .ld_val_i (wdata_i[CNT_W-1:0]),
    .clr_i    (wr_stat && wdata_i[DATA_W-1]),
    .cnt_o    (cnt),
    .flag_o   (flag)
  );

  assign irq_o = flag & ctrl_q.irq_en;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_DATA: rdata_o = data;
      ADDR_STAT: begin
        rdata_o[DATA_W-1]  = flag;
        rdata_o[CNT_W-1:0] = cnt;
      end
      ADDR_CTRL: begin
        rdata_o[CTRL_IE]   = ctrl_q.irq_en;
        rdata_o[CTRL_INT]  = ctrl_q.int_clk;
        rdata_o[CTRL_MODE] = ctrl_q.mode;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: tb/sim_tw_shift_engine.sv
module sim_tw_shift_engine;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       sck_i = 1'b0, sck_o, di_i = 1'b0, do_o, irq_o;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;
  logic [7:0] ctrl_base = 8'h00;

  always #2 clk = ~clk;

  tw_shift_engine u0 (
    .clk_i(clk), .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .sck_i, .sck_o, .di_i, .do_o, .irq_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_stat(input bit f, input int c);
    return (f ? 8'h80 : 8'h00) | (c % 16);
  endfunction

  // one edge of the selected serial clock
  task automatic sedge(input bit ext);
    if (ext) begin
      @(negedge clk); sck_i = ~sck_i; idle(6);
    end else begin
      wr(2'd2, ctrl_base | 8'h01); idle(3);
    end
  endtask

  task automatic xfer(input logic [7:0] m, input logic [7:0] s, input bit ext, input string tag);
    logic [7:0] r;
    wr(2'd0, m);
    wr(2'd1, 8'h80);
    di_i = s[7];
    idle(1);
    chk({tag, " R11 do after load"}, do_o, m[7]);
    for (int i = 0; i < 8; i++) begin
      sedge(ext);
      chk({tag, " R4 do at sample edge"}, do_o, m[7-i]);
      rd(2'd1, r);
      chk({tag, " R5 count mid-bit"}, r, exp_stat(0, 2*i+1));
      sedge(ext);
      if (i < 7) di_i = s[6-i];
      rd(2'd1, r);
      chk({tag, " R6 count/flag after bit"}, r, exp_stat(i == 7, 2*i+2));
    end
    rd(2'd0, r);
    chk({tag, " R4 received byte"}, r, s);
  endtask

  initial begin
    logic [7:0] r, m, s;
    int c;
    void'($urandom(32'd1234));
    idle(3);
    chk("R1 sck_o", sck_o, 0);
    chk("R1 do_o", do_o, 0);
    chk("R1 irq_o", irq_o, 0);
    rst_ni = 1'b1;
    rd(2'd0, r); chk("R1 data", r, 0);
    rd(2'd1, r); chk("R1 status", r, 0);
    rd(2'd2, r); chk("R1 ctrl", r, 0);

    // mode 0, internal clock, idle low
    ctrl_base = 8'h04;
    wr(2'd2, ctrl_base);
    wr(2'd2, ctrl_base | 8'h01);
    idle(1);
    chk("R7 sck_o toggled", sck_o, 1);
    rd(2'd2, r); chk("R7 strobe reads 0", r, 8'h04);
    wr(2'd2, ctrl_base | 8'h01);
    idle(1);
    chk("R7 sck_o back", sck_o, 0);
    xfer(8'hA5, 8'h3C, 1'b0, "R2 m0 directed");
    xfer(8'h00, 8'hFF, 1'b0, "R2 m0 zeros/ones");
    for (int k = 0; k < 4; k++) begin
      m = 8'($urandom); s = 8'($urandom);
      xfer(m, s, 1'b0, "R2 m0 random");
    end

    // pin ignored while internal clock selected
    wr(2'd1, 8'h80);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); sck_i = ~sck_i; idle(5);
    end
    rd(2'd1, r); chk("R10 pin ignored count", r, 0);
    chk("R10 sck_o unaffected", sck_o, 0);

    // external clock, mode 0 (pin and toggle both low)
    ctrl_base = 8'h00;
    wr(2'd2, ctrl_base);
    idle(4);
    xfer(8'h5A, 8'hC3, 1'b1, "R10 ext");

    // mode 1, internal clock, idle high
    ctrl_base = 8'h06;
    wr(2'd2, ctrl_base);
    wr(2'd2, ctrl_base | 8'h01);
    idle(3);
    chk("R3 idle high", sck_o, 1);
    xfer(8'h96, 8'h69, 1'b0, "R3 m1 directed");
    for (int k = 0; k < 4; k++) begin
      m = 8'($urandom); s = 8'($urandom);
      xfer(m, s, 1'b0, "R3 m1 random");
    end

    // flag set from last transfer: load without clearing
    wr(2'd1, 8'h0E);
    rd(2'd1, r); chk("R8 load keeps flag", r, 8'h8E);
    wr(2'd1, 8'h8E);
    rd(2'd1, r); chk("R8 clear and load", r, 8'h0E);
    sedge(1'b0); sedge(1'b0);
    rd(2'd1, r); chk("R6 wrap from loaded 14", r, 8'h80);

    // interrupt gating
    chk("R9 irq off without enable", irq_o, 0);
    ctrl_base = 8'h0E;
    wr(2'd2, ctrl_base); idle(1);
    chk("R9 irq with enable", irq_o, 1);
    wr(2'd1, 8'h80); idle(1);
    chk("R9 irq after clear", irq_o, 0);
    c = 0;
    for (int k = 0; k < 16; k++) begin
      sedge(1'b0);
      c++;
      if (k == 14) chk("R6 no flag at 15", irq_o, 0);
    end
    chk("R9 irq after wrap", irq_o, 1);
    ctrl_base = 8'h06;
    wr(2'd2, ctrl_base); idle(1);
    chk("R9 irq gated off", irq_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule